// File: doc/BRIEF.md
# Low-Power Wakeup Event Controller

This block gathers wakeup events while the processor sleeps and turns them into one wakeup request for the power manager. It watches two general-purpose pin ports, each `GPIO_W` bits wide. Every pin passes through a synchroniser and an edge detector. Any change of level, rising or falling, sets a sticky status bit. Three low-power peripheral sources (timer 0, timer 1 and the low-power UART) deliver single-cycle event pulses, and each pulse sets a sticky peripheral flag.

Status capture does not depend on any enable. A source wakes the system only when it is enabled. A pin needs its own enable bit and the global pin-wakeup gate input. A peripheral needs only its own enable bit. Software reads the status and enable registers over a small word-addressed bus. It clears events by writing ones to the status registers.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset, all six registers read zero and `wake_req` is low.
- R2: A rising or a falling change on a pin sets that pin's status bit on the third rising clock edge after the change: two synchroniser flops, then the edge register. A pin that holds its level sets nothing.
- R3: Pin status bits latch whether or not the pin's enable bit or the global gate is set.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits clear only through such a write.
- R5: When a hardware set and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R6: `wake_req` is high while some pin of either port has its status and enable bits both set and `gpio_wake_gate` is high. Lowering the gate suppresses pin wakeups. The two ports act independently.
- R7: A one-cycle pulse on `lp_evt` bit 0 (timer 0), bit 1 (timer 1) or bit 2 (UART) sets the same bit of the peripheral status register. The bit stays set until it is cleared.
- R8: `wake_req` is high while a peripheral flag and the matching peripheral enable bit are both set, whatever the level of `gpio_wake_gate`.
- R9: Byte offsets on `bus_addr`: port A status 0x04, port A enable 0x08, port B status 0x0C, port B enable 0x10, peripheral status 0x30, peripheral enable 0x34. Any other offset reads zero. Bits at or above `GPIO_W` (pin registers) or 3 (peripheral registers) read zero and ignore writes.
- R10: A pin level held through reset does not set a status bit after reset is released. A later change of that pin sets its bit as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken with `bus_sel` on a rising edge |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_a_pin | input | GPIO_W | Port A pins, asynchronous |
| gpio_b_pin | input | GPIO_W | Port B pins, asynchronous |
| gpio_wake_gate | input | 1 | Global enable for pin wakeups |
| lp_evt | input | PERIPH_N | Peripheral event pulses: timer 0, timer 1, UART |
| wake_req | output | 1 | Wakeup request to the power manager |

## Verification
The bench builds the block with `GPIO_W` = 8, `SYNC_STAGES` = 2 and `PERIPH_N` = 3. The narrow ports leave bits 8 to 31 of every pin register unimplemented. Reads and writes can therefore show that those bits stay zero. The edge-to-status delay is three edges, so the bench can check the exact capture cycle and the cycle before it. It can also line up a pin edge and a clearing write on the same edge.

// File: rtl/lpwake_pkg.sv
// Package: shared constants and register-select type for the wakeup
// controller. Assumes a 32-bit data bus and byte offsets on an 8-bit address.
package lpwake_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_PORTS = 2;

    localparam logic [ADDR_W-1:0] OFS_GPIO_BASE = 8'h04;
    localparam logic [ADDR_W-1:0] GPIO_STRIDE   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PSTAT     = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_PEN       = 8'h34;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_GSTAT,
        RS_GEN,
        RS_PSTAT,
        RS_PEN
    } rsel_e;

    // Status register offset of pin port p.
    function automatic logic [ADDR_W-1:0] gpio_stat_ofs(input int p);
        return OFS_GPIO_BASE + ADDR_W'(p) * GPIO_STRIDE;
    endfunction

    // Enable register offset of pin port p (one word above its status).
    function automatic logic [ADDR_W-1:0] gpio_en_ofs(input int p);
        return gpio_stat_ofs(p) + 8'h04;
    endfunction

endpackage

// File: rtl/lpwake_sync.sv
// Module: multi-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency across bits is implied.
module lpwake_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/lpwake_gpio_port.sv
// Module: one pin port. Synchronises the pins, detects either edge, keeps
// sticky status with write-one-to-clear (a set wins over a clear), and
// holds the per-pin enable register. Assumes edges are held at least one
// clock; edges are ignored until the synchroniser has filled after reset.
module lpwake_gpio_port #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic         clr_stb,
    input  logic         en_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         pending
);

    logic [W-1:0]    synced;
    logic [W-1:0]    prev;
    logic [STAGES:0] arm;
    logic [W-1:0]    edges;
    logic [W-1:0]    clr_mask;

    lpwake_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin),
        .q     (synced)
    );

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= synced;
    end

    // Fill an arming shift register so edges count only once the chain holds real samples.
    always_ff @(posedge clk) begin
        if (!rst_n) arm <= '0;
        else        arm <= {arm[STAGES-1:0], 1'b1};
    end

    // Either-direction change, masked until armed.
    always_comb begin
        edges    = arm[STAGES] ? (synced ^ prev) : '0;
        clr_mask = clr_stb ? wdata : '0;
    end

    // Sticky status: clear by written ones, then new edges override.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | edges;
    end

    // Per-pin enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      enable <= '0;
        else if (en_stb) enable <= wdata;
    end

    assign pending = |(status & enable);

endmodule

// File: rtl/lpwake_periph.sv
// Module: peripheral wakeup flags and enables. Assumes each event input is a
// synchronous single-cycle pulse; a set wins over a same-cycle clear.
module lpwake_periph #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_stb,
    input  logic         en_stb,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         pending
);

    logic [N-1:0] clr_mask;

    // Select the clearing mask only on a status write.
    always_comb clr_mask = clr_stb ? wdata : '0;

    // Sticky flags set by event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | evt;
    end

    // Per-source enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      enable <= '0;
        else if (en_stb) enable <= wdata;
    end

    assign pending = |(status & enable);

endmodule

// File: rtl/lpwake_ctrl.sv
// Module: top of the wakeup controller. Decodes the register bus, builds two
// pin ports and the peripheral flag block, and merges the enabled pending
// sources into one wakeup request. Assumes GPIO_W <= 32 and PERIPH_N <= 32;
// reads are combinational and have no side effects.
module lpwake_ctrl
    import lpwake_pkg::*;
#(
    parameter int GPIO_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter int PERIPH_N    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [GPIO_W-1:0]   gpio_a_pin,
    input  logic [GPIO_W-1:0]   gpio_b_pin,
    input  logic                gpio_wake_gate,
    input  logic [PERIPH_N-1:0] lp_evt,
    output logic                wake_req
);

    logic                             bus_we;
    logic [NUM_PORTS-1:0][GPIO_W-1:0] pins;
    logic [NUM_PORTS-1:0][GPIO_W-1:0] gpio_stat;
    logic [NUM_PORTS-1:0][GPIO_W-1:0] gpio_en;
    logic [NUM_PORTS-1:0]             gpio_clr;
    logic [NUM_PORTS-1:0]             gpio_wen;
    logic [NUM_PORTS-1:0]             gpio_pend;
    logic [PERIPH_N-1:0]              p_stat;
    logic [PERIPH_N-1:0]              p_en;
    logic                             p_pend;
    rsel_e                            rsel;
    logic                             rport;
    logic                             unused_wdata_hi;

    assign bus_we          = bus_sel && bus_wr;
    assign pins[0]         = gpio_a_pin;
    assign pins[1]         = gpio_b_pin;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PERIPH_N];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign gpio_clr[p] = bus_we && (bus_addr == gpio_stat_ofs(p));
        assign gpio_wen[p] = bus_we && (bus_addr == gpio_en_ofs(p));

        lpwake_gpio_port #(.W(GPIO_W), .STAGES(SYNC_STAGES)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pins[p]),
            .clr_stb (gpio_clr[p]),
            .en_stb  (gpio_wen[p]),
            .wdata   (bus_wdata[GPIO_W-1:0]),
            .status  (gpio_stat[p]),
            .enable  (gpio_en[p]),
            .pending (gpio_pend[p])
        );
    end

    lpwake_periph #(.N(PERIPH_N)) u_periph (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (lp_evt),
        .clr_stb (bus_we && (bus_addr == OFS_PSTAT)),
        .en_stb  (bus_we && (bus_addr == OFS_PEN)),
        .wdata   (bus_wdata[PERIPH_N-1:0]),
        .status  (p_stat),
        .enable  (p_en),
        .pending (p_pend)
    );

    // Work out which register the address selects.
    always_comb begin
        rsel  = RS_NONE;
        rport = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == gpio_stat_ofs(p)) begin
                rsel  = RS_GSTAT;
                rport = 1'(p);
            end
            if (bus_addr == gpio_en_ofs(p)) begin
                rsel  = RS_GEN;
                rport = 1'(p);
            end
        end
        if (bus_addr == OFS_PSTAT) rsel = RS_PSTAT;
        if (bus_addr == OFS_PEN)   rsel = RS_PEN;
    end

    // Return the selected register, zero-extended.
    always_comb begin
        case (rsel)
            RS_GSTAT: bus_rdata = DATA_W'(gpio_stat[rport]);
            RS_GEN:   bus_rdata = DATA_W'(gpio_en[rport]);
            RS_PSTAT: bus_rdata = DATA_W'(p_stat);
            RS_PEN:   bus_rdata = DATA_W'(p_en);
            default:  bus_rdata = '0;
        endcase
    end

    // Merge gated pin wakeups and peripheral wakeups.
    assign wake_req = (gpio_wake_gate && (|gpio_pend)) || p_pend;

endmodule

// File: rtl/lpwake_checker.sv
// Module: assertion checker for lpwake_ctrl, bound to every instance.
// Assumes reset is held for at least two clocks at start-up.
module lpwake_checker
    import lpwake_pkg::*;
#(
    parameter int GPIO_W   = 32,
    parameter int PERIPH_N = 3
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_sel,
    input logic                             bus_wr,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [DATA_W-1:0]                bus_wdata,
    input logic [DATA_W-1:0]                bus_rdata,
    input logic                             gpio_wake_gate,
    input logic [PERIPH_N-1:0]              lp_evt,
    input logic                             wake_req,
    input logic [NUM_PORTS-1:0][GPIO_W-1:0] gpio_stat,
    input logic [NUM_PORTS-1:0][GPIO_W-1:0] gpio_en,
    input logic [PERIPH_N-1:0]              p_stat,
    input logic [PERIPH_N-1:0]              p_en
);

    logic [PERIPH_N-1:0] pclr_mask;
    logic [GPIO_W-1:0]   aclr_mask;
    logic                unused_wdata_hi;

    assign pclr_mask = (bus_sel && bus_wr && bus_addr == OFS_PSTAT)
                       ? bus_wdata[PERIPH_N-1:0] : '0;
    assign aclr_mask = (bus_sel && bus_wr && bus_addr == OFS_GPIO_BASE)
                       ? bus_wdata[GPIO_W-1:0] : '0;
    assign unused_wdata_hi = ^bus_wdata;

    // R1: registers are clear when reset lifts
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gpio_stat == '0 && gpio_en == '0 && p_stat == '0 && p_en == '0));

    // R4: a peripheral flag drops only after a clearing write
    a_r4_pflag_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(p_stat) & ~p_stat) & ~$past(pclr_mask)) == '0));

    // R4: a port A status bit drops only after a clearing write
    a_r4_gpio_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(gpio_stat[0]) & ~gpio_stat[0]) & ~$past(aclr_mask)) == '0));

    // R7 and R5: every event pulse is held as a flag on the next cycle
    a_r7_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|lp_evt) |=> ((p_stat & $past(lp_evt)) == $past(lp_evt)));

    // R6: an enabled pending pin with the gate open raises the request
    a_r6_gpio_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_wake_gate && ((|(gpio_stat[0] & gpio_en[0])) || (|(gpio_stat[1] & gpio_en[1]))))
        |-> wake_req);

    // R6: with the gate closed only peripherals may raise the request
    a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!gpio_wake_gate && !(|(p_stat & p_en))) |-> !wake_req);

    // R8: an enabled pending peripheral raises the request
    a_r8_periph_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (|(p_stat & p_en)) |-> wake_req);

    // R9: unimplemented peripheral bits read zero
    a_r9_periph_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_PSTAT || bus_addr == OFS_PEN) |-> (bus_rdata[DATA_W-1:PERIPH_N] == '0));

endmodule

bind lpwake_ctrl lpwake_checker #(.GPIO_W(GPIO_W), .PERIPH_N(PERIPH_N)) u_chk (.*);

// File: tb/lpwake_ctrl_test.sv
`timescale 1ns/100ps
module lpwake_ctrl_test;

    localparam int GW = 8;
    localparam int PN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [GW-1:0] pa = '0;
    logic [GW-1:0] pb = '0;
    logic          gate = 1'b0;
    logic [PN-1:0] evt = '0;
    logic          wake_req;

    int checks = 0;
    int errors = 0;

    lpwake_ctrl #(.GPIO_W(GW), .SYNC_STAGES(2), .PERIPH_N(PN)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_sel        (bus_sel),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .gpio_a_pin     (pa),
        .gpio_b_pin     (pb),
        .gpio_wake_gate (gate),
        .lp_evt         (evt),
        .wake_req       (wake_req)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Read combinationally at the current time, between edges.
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // Change pins of a port and wait until the status is captured (third edge).
    task automatic set_pins(input int port, input logic [GW-1:0] v);
        @(negedge clk);
        if (port == 0) pa = v; else pb = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        peek(8'h04, d); chk("R1 stat A", d, 0);
        peek(8'h08, d); chk("R1 en A", d, 0);
        peek(8'h0C, d); chk("R1 stat B", d, 0);
        peek(8'h10, d); chk("R1 en B", d, 0);
        peek(8'h30, d); chk("R1 pstat", d, 0);
        peek(8'h34, d); chk("R1 pen", d, 0);
        chk("R1 wake", 32'(wake_req), 0);
    endtask

    task automatic t_edges;
        logic [31:0] d;
        @(negedge clk);
        pa = 8'h01;
        repeat (2) @(negedge clk);
        peek(8'h04, d); chk("R2 not yet after two edges", d, 0);
        @(negedge clk);
        peek(8'h04, d); chk("R2 rise captured on third edge", d, 32'h01);
        chk("R3 no wake while disabled", 32'(wake_req), 0);
        wr(8'h04, 32'h01);
        repeat (4) @(negedge clk);
        peek(8'h04, d); chk("R2 steady pin sets nothing", d, 0);
        set_pins(0, 8'h00);
        peek(8'h04, d); chk("R2 fall captured", d, 32'h01);
        set_pins(1, 8'h80);
        peek(8'h0C, d); chk("R3 port B bit7 without enable", d, 32'h80);
        peek(8'h04, d); chk("R6 port A untouched by port B", d, 32'h01);
        wr(8'h04, 32'hFF);
        wr(8'h0C, 32'hFF);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        set_pins(0, 8'h06);
        peek(8'h04, d); chk("R2 two bits", d, 32'h06);
        wr(8'h04, 32'h02);
        peek(8'h04, d); chk("R4 clear bit1 only", d, 32'h04);
        wr(8'h04, 32'h00);
        peek(8'h04, d); chk("R4 writing zero keeps", d, 32'h04);
        wr(8'h04, 32'h04);
        peek(8'h04, d); chk("R4 cleared", d, 0);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        @(negedge clk);
        pa = pa ^ 8'h20;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h20;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        peek(8'h04, d); chk("R5 pin set beats clear", d, 32'h20);
        wr(8'h04, 32'h20);
        @(negedge clk);
        evt = 3'b010;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h2;
        @(negedge clk);
        evt = '0;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        peek(8'h30, d); chk("R5 event set beats clear", d, 32'h2);
        wr(8'h30, 32'h7);
    endtask

    task automatic t_gpio_wake;
        logic [31:0] d;
        wr(8'h08, 32'h10);
        gate = 1'b1;
        set_pins(0, pa ^ 8'h10);
        #0.5; chk("R6 port A wake", 32'(wake_req), 1);
        @(negedge clk); gate = 1'b0;
        #0.5; chk("R6 gate low blocks", 32'(wake_req), 0);
        gate = 1'b1;
        #0.5; chk("R6 gate high again", 32'(wake_req), 1);
        wr(8'h04, 32'h10);
        chk("R6 cleared drops wake", 32'(wake_req), 0);
        wr(8'h10, 32'h01);
        set_pins(1, pb ^ 8'h01);
        #0.5; chk("R6 port B wake", 32'(wake_req), 1);
        wr(8'h10, 32'h00);
        chk("R6 disable drops wake", 32'(wake_req), 0);
        peek(8'h0C, d); chk("R3 status kept after disable", d, 32'h01);
        wr(8'h0C, 32'h01);
        wr(8'h08, 32'h00);
        gate = 1'b0;
    endtask

    task automatic t_periph;
        logic [31:0] d;
        @(negedge clk); evt = 3'b010;
        @(negedge clk); evt = '0;
        repeat (3) @(negedge clk);
        peek(8'h30, d); chk("R7 timer1 flag sticky", d, 32'h2);
        chk("R8 no wake without enable", 32'(wake_req), 0);
        wr(8'h34, 32'h2);
        chk("R8 wake with gate low", 32'(wake_req), 1);
        wr(8'h30, 32'h2);
        chk("R8 clear drops wake", 32'(wake_req), 0);
        @(negedge clk); evt = 3'b001;
        @(negedge clk); evt = 3'b100;
        @(negedge clk); evt = '0;
        peek(8'h30, d); chk("R7 timer0 and uart", d, 32'h5);
        chk("R8 disabled sources no wake", 32'(wake_req), 0);
        wr(8'h30, 32'h5);
        wr(8'h34, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(8'h08, 32'hFFFF_FFFF);
        peek(8'h08, d); chk("R9 enable A width", d, 32'h0000_00FF);
        wr(8'h10, 32'hA5A5_A55A);
        peek(8'h10, d); chk("R9 enable B", d, 32'h0000_005A);
        wr(8'h34, 32'hFFFF_FFFF);
        peek(8'h34, d); chk("R9 periph enable width", d, 32'h7);
        peek(8'h20, d); chk("R9 unmapped offset", d, 0);
        wr(8'h20, 32'hFFFF_FFFF);
        peek(8'h08, d); chk("R9 unmapped write ignored", d, 32'h0000_00FF);
        wr(8'h08, 0); wr(8'h10, 0); wr(8'h34, 0);
    endtask

    task automatic t_reset_high;
        logic [31:0] d;
        @(negedge clk);
        rst_n = 1'b0;
        pa = 8'h08;
        pb = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        peek(8'h04, d); chk("R10 held level ignored", d, 0);
        set_pins(0, 8'h00);
        peek(8'h04, d); chk("R10 later change captured", d, 32'h08);
        wr(8'h04, 32'h08);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edges();
        t_w1c();
        t_set_wins();
        t_gpio_wake();
        t_periph();
        t_map();
        t_reset_high();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule